// File: doc/BRIEF.md
# Register Halfword Mask Test Unit

This block tests a chosen 16-bit halfword of a 64-bit register against a 16-bit mask and reduces the result to a 2-bit condition code. The caller presents the register value, the mask, a 2-bit halfword selector, a 4-bit branch mask and a valid strobe. One clock later the block returns the condition code, a branch-taken flag and an output valid strobe. The register value is only read.

Unlike a plain byte mask test, a mixed result is split in two. The code depends on the value of the leftmost tested bit, which is the most significant halfword bit position where the mask holds a 1. The branch flag is the bit of the branch mask that belongs to the code computed from the same input. Bits are numbered from the most significant end of the register, starting at bit 0. That numbering is what the selector refers to.

Top module: `regtest_cond_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid, cc_o and br_taken are all 0.
- R2: hw_sel picks the tested halfword. Value 0 selects register bits 0–15, which are reg_val[63:48]. Value 1 selects bits 16–31 (reg_val[47:32]), value 2 selects bits 32–47 (reg_val[31:16]) and value 3 selects bits 48–63 (reg_val[15:0]).
- R3: cc_o is 0 when the mask is all zeros or when every tested bit of the selected halfword is 0.
- R4: cc_o is 3 when the mask is non-zero and every tested bit is 1.
- R5: For a mixed result whose leftmost tested bit is 0, cc_o is 1. The leftmost tested bit is the highest set mask bit index within the halfword.
- R6: For a mixed result whose leftmost tested bit is 1, cc_o is 2. For example, register value 2 tested in halfword 3 with mask 0x0003 gives code 2.
- R7: br_taken equals br_mask[3 - cc_o]. Bit 3 (weight 8) selects code 0, bit 2 (weight 4) selects code 1, bit 1 (weight 2) selects code 2 and bit 0 (weight 1) selects code 3. The code used is the one computed from the same input.
- R8: Results appear on the cycle after in_valid is high. out_valid is high on exactly those cycles.
- R9: When in_valid is low, cc_o and br_taken keep their previous values, whatever the other inputs do.
- R10: Register bits outside the selected halfword have no effect on cc_o or br_taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| reg_val | input | 64 | Register value under test |
| mask | input | 16 | Bit mask applied to the halfword |
| hw_sel | input | 2 | Halfword selector (0 = most significant) |
| br_mask | input | 4 | Branch mask, bit 3 selects code 0 |
| out_valid | output | 1 | Result strobe |
| cc_o | output | 2 | Condition code |
| br_taken | output | 1 | Branch decision |

## Verification
Condition evaluation and branch selection occur in the same cycle. The branch decision must use the code computed from the current input, not the code held in the output register from the previous input. To provoke this, the bench applies two back-to-back valid inputs with the same branch mask. The branch mask has exactly one bit set, and that bit matches the first input's code but not the second's. The bench judges the result by checking that br_taken rises with the first result and falls with the second, each time in the same cycle as the new cc_o.

// File: rtl/tum_pkg.sv
package tum_pkg;
  localparam int CC_W = 2;
  typedef logic [CC_W-1:0] cc_t;
  localparam cc_t CC_NONE  = 2'd0;
  localparam cc_t CC_MIX_0 = 2'd1;
  localparam cc_t CC_MIX_1 = 2'd2;
  localparam cc_t CC_ALL   = 2'd3;
endpackage

// File: rtl/tum_hw_pick.sv
module tum_hw_pick #(
  parameter int REG_W = 64,
  parameter int HW_W  = 16,
  localparam int NUM_HW = REG_W / HW_W,
  localparam int SEL_W  = $clog2(NUM_HW)
) (
  input  logic [REG_W-1:0] reg_val,
  input  logic [SEL_W-1:0] sel,
  output logic [HW_W-1:0]  hw_out
);
  logic [HW_W-1:0] slices [NUM_HW];

  // Index 0 is the most significant halfword.
  for (genvar g = 0; g < NUM_HW; g++) begin : g_slice
    assign slices[g] = reg_val[REG_W-1-g*HW_W -: HW_W];
  end

  assign hw_out = slices[sel];
endmodule

// File: rtl/tum_mask_eval.sv
module tum_mask_eval
  import tum_pkg::*;
#(
  parameter int HW_W = 16
) (
  input  logic [HW_W-1:0] hw,
  input  logic [HW_W-1:0] mask,
  output cc_t             cc
);
  logic [HW_W-1:0] tested;
  logic            lead_bit;

  assign tested = hw & mask;

  // The highest set mask bit wins: later loop iterations override earlier ones.
  always_comb begin
    lead_bit = 1'b0;
    for (int i = 0; i < HW_W; i++) begin
      if (mask[i]) lead_bit = hw[i];
    end
  end

  always_comb begin
    if (tested == '0)        cc = CC_NONE;
    else if (tested == mask) cc = CC_ALL;
    else if (lead_bit)       cc = CC_MIX_1;
    else                     cc = CC_MIX_0;
  end
endmodule

// File: rtl/tum_branch_sel.sv
module tum_branch_sel
  import tum_pkg::*;
(
  input  cc_t        cc,
  input  logic [3:0] br_mask,
  output logic       taken
);
  // Bit 3 belongs to code 0, bit 0 to code 3.
  logic [1:0] idx;
  assign idx   = 2'd3 - cc;
  assign taken = br_mask[idx];
endmodule

// File: rtl/regtest_cond_unit.sv
module regtest_cond_unit
  import tum_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int HW_W  = 16,
  localparam int NUM_HW = REG_W / HW_W,
  localparam int SEL_W  = $clog2(NUM_HW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [63:0]      reg_val,
  input  logic [15:0]      mask,
  input  logic [1:0]       hw_sel,
  input  logic [3:0]       br_mask,
  output logic             out_valid,
  output logic [1:0]       cc_o,
  output logic             br_taken
);
  logic [HW_W-1:0] sel_hw;
  cc_t             cc_next;
  logic            taken_next;

  tum_hw_pick #(.REG_W(REG_W), .HW_W(HW_W)) u_pick (
    .reg_val (reg_val),
    .sel     (hw_sel),
    .hw_out  (sel_hw)
  );

  tum_mask_eval #(.HW_W(HW_W)) u_eval (
    .hw   (sel_hw),
    .mask (mask),
    .cc   (cc_next)
  );

  tum_branch_sel u_br (
    .cc      (cc_next),
    .br_mask (br_mask),
    .taken   (taken_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cc_o      <= CC_NONE;
      br_taken  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cc_o     <= cc_next;
        br_taken <= taken_next;
      end
    end
  end

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(cc_o) && $stable(br_taken)));
  // R3
  empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask == 16'h0) |=> (cc_o == 2'd0));
  // R4
  all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask != 16'h0 && (sel_hw & mask) == mask) |=> (cc_o == 2'd3));
  // R7
  branch_always_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && br_mask == 4'hF) |=> br_taken);
  // R7
  branch_never_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && br_mask == 4'h0) |=> !br_taken);
endmodule

// File: tb/regtest_cond_unit_test.sv
module regtest_cond_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] reg_val = '0;
  logic [15:0] mask = '0;
  logic [1:0]  hw_sel = '0;
  logic [3:0]  br_mask = '0;
  logic        out_valid;
  logic [1:0]  cc_o;
  logic        br_taken;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  regtest_cond_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .reg_val(reg_val),
    .mask(mask), .hw_sel(hw_sel), .br_mask(br_mask),
    .out_valid(out_valid), .cc_o(cc_o), .br_taken(br_taken)
  );

  function automatic logic [1:0] exp_cc(logic [63:0] r, logic [15:0] m, logic [1:0] s);
    logic [15:0] h;
    logic [15:0] t;
    logic        lead;
    h = 16'(r >> (48 - 16 * int'(s)));
    t = h & m;
    lead = 1'b0;
    for (int i = 0; i < 16; i++) if (m[i]) lead = h[i];
    if (t == 16'h0) return 2'd0;
    if (t == m)     return 2'd3;
    return lead ? 2'd2 : 2'd1;
  endfunction

  function automatic logic exp_br(logic [3:0] bm, logic [1:0] c);
    return bm[3 - int'(c)];
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one valid input at a falling edge, then check at the next falling edge.
  task automatic run_one(string req, logic [63:0] r, logic [15:0] m,
                         logic [1:0] s, logic [3:0] bm);
    @(negedge clk);
    reg_val = r; mask = m; hw_sel = s; br_mask = bm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " cc"}, int'(cc_o), int'(exp_cc(r, m, s)));
    check({req, " branch"}, int'(br_taken), int'(exp_br(bm, exp_cc(r, m, s))));
  endtask

  task automatic t_reset();
    check("R1 valid", int'(out_valid), 0);
    check("R1 cc", int'(cc_o), 0);
    check("R1 branch", int'(br_taken), 0);
  endtask

  task automatic t_select();
    logic [63:0] r = 64'hFFFF_0000_00F0_5A02;
    run_one("R2 hw0", r, 16'hFFFF, 2'd0, 4'h1);
    check("R2 hw0 code", int'(cc_o), 3);
    run_one("R2 hw1", r, 16'hFFFF, 2'd1, 4'h8);
    check("R2 hw1 code", int'(cc_o), 0);
    run_one("R2 hw2", r, 16'hFFFF, 2'd2, 4'h4);
    check("R2 hw2 code", int'(cc_o), 1);
    run_one("R2 hw3", r, 16'h4000, 2'd3, 4'h1);
    check("R2 hw3 code", int'(cc_o), 3);
  endtask

  task automatic t_codes();
    run_one("R3 mask zero", 64'hFFFF_FFFF_FFFF_FFFF, 16'h0000, 2'd3, 4'h8);
    check("R3 code", int'(cc_o), 0);
    run_one("R3 bits zero", 64'h0000_0000_0000_FF00, 16'h00FF, 2'd3, 4'h8);
    run_one("R4 all ones", 64'h0000_0000_0000_0F0F, 16'h0F0F, 2'd3, 4'h1);
    check("R4 code", int'(cc_o), 3);
    run_one("R5 mixed lead0", 64'h0000_0000_0000_0001, 16'h8001, 2'd3, 4'h4);
    check("R5 code", int'(cc_o), 1);
    run_one("R6 example", 64'h0000_0000_0000_0002, 16'h0003, 2'd3, 4'h2);
    check("R6 code", int'(cc_o), 2);
    run_one("R6 mixed lead1", 64'h8000_0000_0000_0000, 16'hC000, 2'd0, 4'h2);
  endtask

  task automatic t_branch();
    logic [63:0] regs [4] = '{64'h0, 64'h1, 64'h2, 64'h3};
    for (int c = 0; c < 4; c++) begin
      for (int b = 0; b < 16; b++) begin
        run_one("R7 branch map", regs[c], 16'h0003, 2'd3, 4'(b));
      end
    end
  endtask

  task automatic t_outside();
    run_one("R10 others set", 64'hFFFF_FFFF_0000_FFFF, 16'hFFFF, 2'd2, 4'h8);
    check("R10 code", int'(cc_o), 0);
    run_one("R10 others clear", 64'h0000_FFFF_0000_0000, 16'h8001, 2'd1, 4'h1);
    check("R10 code ones", int'(cc_o), 3);
  endtask

  task automatic t_hold();
    run_one("R9 setup", 64'h0000_0000_0000_0002, 16'h0003, 2'd3, 4'h2);
    reg_val = 64'hFFFF_FFFF_FFFF_FFFF; mask = 16'hFFFF; br_mask = 4'h0; hw_sel = 2'd0;
    @(negedge clk);
    check("R9 valid low", int'(out_valid), 0);
    check("R9 cc held", int'(cc_o), 2);
    check("R9 branch held", int'(br_taken), 1);
    @(negedge clk);
    check("R8 valid stays low", int'(out_valid), 0);
    check("R9 cc still held", int'(cc_o), 2);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    reg_val = 64'h0000_0000_0000_0001; mask = 16'h0003; hw_sel = 2'd3;
    br_mask = 4'h4; in_valid = 1'b1;
    @(negedge clk);
    check("R7 first code", int'(cc_o), 1);
    check("R7 first taken", int'(br_taken), 1);
    reg_val = 64'h0000_0000_0000_0002;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 back-to-back valid", int'(out_valid), 1);
    check("R7 second code", int'(cc_o), 2);
    check("R7 second not taken", int'(br_taken), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_select();
    t_codes();
    t_branch();
    t_outside();
    t_hold();
    t_same_cycle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule